// File: doc/BRIEF.md
# Burst-Notifying Receive Byte Buffer

This block sits between the byte stream that a memory-card data line delivers during a block read and a processor that drains those bytes through one read port. The host sets a receive-enable level to start a block. While it is high, every byte strobed in on the stream side goes into a small first-in first-out store. When enough unread bytes are waiting for one burst (eight by default), the block raises a ready status that software can poll. On the same event it sets a sticky ready flag that drives an interrupt line through a mask.

A handler normally masks the interrupt and reads one burst of eight bytes. It then clears the flag and unmasks. The host repeats this until the block has been fully received. Dropping the enable level flushes the store and returns every indication to its idle value. Two sticky error bits report a read from an empty store (underrun) and a byte that arrived while the store was full (overrun).

Top module: `rxburst_fifo`

## Requirements
- R1: While `data_en` is 0, the following hold from the next clock edge on: the store is empty, and `burst_ready`, `burst_flag`, `overrun` and `underrun` read 0. Stream bytes and read strobes are ignored, and `rd_byte` keeps its value.
- R2: While `data_en` is 1, bytes accepted on `in_valid` are returned on `rd_byte` in arrival order. Each `rd_strobe` pops one byte, and that byte appears on `rd_byte` after the clock edge that sampled the strobe.
- R3: `burst_ready` is 1 exactly when the store holds at least BURST (default 8) unread bytes.
- R4: `burst_flag` becomes 1 on the same edge at which `burst_ready` goes from 0 to 1. It then stays at 1 until it is cleared.
- R5: A `flag_clr` pulse clears `burst_flag` at the next edge. If a new ready rise happens on that same edge, the flag stays set.
- R6: `irq` is 1 exactly when `burst_flag` is 1 and `irq_mask` is 0.
- R7: A read strobe on an empty store leaves `rd_byte` unchanged and sets the sticky `underrun` bit.
- R8: A stream byte that arrives while the store holds DEPTH (default 16) bytes is dropped, and the sticky `overrun` bit is set. The store never holds more than DEPTH bytes.
- R9: When a read and a write happen on the same edge with the store neither empty nor full, the fill level stays the same and both operations take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_en | input | 1 | Receive enable; 0 flushes the store |
| in_valid | input | 1 | Stream byte strobe |
| in_byte | input | 8 | Stream byte |
| rd_strobe | input | 1 | Host read request, one byte per cycle |
| rd_byte | output | 8 | Last byte popped by the host |
| irq_mask | input | 1 | 1 blocks the flag from reaching `irq` |
| flag_clr | input | 1 | Write-one-to-clear pulse for `burst_flag` |
| burst_ready | output | 1 | Pollable status: at least one burst is waiting |
| burst_flag | output | 1 | Sticky ready event flag |
| irq | output | 1 | Masked interrupt request |
| overrun | output | 1 | Sticky: a byte was dropped on a full store |
| underrun | output | 1 | Sticky: a read found the store empty |

## Verification
The bench fills the store to exactly sixteen and pushes one more byte. A design that wraps its pointer there would overwrite the oldest byte instead of flagging overrun. It drains past empty to confirm that the last byte is held, since a design that popped a stale slot would return garbage. It also issues a flag clear on the very edge a new burst becomes ready. A design that gave the clear priority would lose that notification. Random traffic with read and write on the same edge, together with mid-block enable drops, catches fill counts that drift or flushes that leave stale ready or error state behind.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int unsigned BYTE_W      = 8;
    localparam int unsigned DEF_DEPTH   = 16;
    localparam int unsigned DEF_BURST   = 8;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_req,
    input  byte_t         wr_byte,
    input  logic          rd_req,
    output byte_t         rd_byte,
    output logic [CW-1:0] level_q,
    output logic [CW-1:0] level_nx,
    output logic          ovf_evt,
    output logic          unf_evt
);
    typedef struct packed {
        logic [DEPTH-1:0][BYTE_W-1:0] mem;
        logic [AW-1:0]                wptr;
        logic [AW-1:0]                rptr;
        logic [CW-1:0]                level;
        byte_t                        rdata;
    } st_t;

    st_t st_d, st_q;
    logic is_full, is_empty, do_wr, do_rd;

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.level == CW'(DEPTH));
        is_empty = (st_q.level == '0);
        do_wr    = !flush && wr_req && !is_full;
        do_rd    = !flush && rd_req && !is_empty;
        ovf_evt  = !flush && wr_req && is_full;
        unf_evt  = !flush && rd_req && is_empty;
        if (flush) begin
            st_d.wptr  = '0;
            st_d.rptr  = '0;
            st_d.level = '0;
        end else begin
            if (do_wr) begin
                st_d.mem[st_q.wptr] = wr_byte;
                st_d.wptr = (st_q.wptr == AW'(DEPTH - 1)) ? '0 : st_q.wptr + 1'b1;
            end
            if (do_rd) begin
                st_d.rdata = st_q.mem[st_q.rptr];
                st_d.rptr  = (st_q.rptr == AW'(DEPTH - 1)) ? '0 : st_q.rptr + 1'b1;
            end
            case ({do_wr, do_rd})
                2'b10:   st_d.level = st_q.level + 1'b1;
                2'b01:   st_d.level = st_q.level - 1'b1;
                default: st_d.level = st_q.level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_byte  = st_q.rdata;
    assign level_q  = st_q.level;
    assign level_nx = st_d.level;

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= CW'(DEPTH));
    a_r1_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level_q == '0));
    a_r9_balanced_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr_req && rd_req && level_q != '0 && level_q != CW'(DEPTH))
        |=> $stable(level_q));
    a_r7_hold_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rd_req && level_q == '0) |=> $stable(rd_byte));
endmodule

// File: rtl/rxb_notify.sv
module rxb_notify
    import rxb_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned BURST = DEF_BURST,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic [CW-1:0] level_q,
    input  logic [CW-1:0] level_nx,
    input  logic          clr_req,
    input  logic          mask,
    input  logic          ovf_evt,
    input  logic          unf_evt,
    output logic          ready,
    output logic          flag,
    output logic          irq,
    output logic          overrun,
    output logic          underrun
);
    typedef struct packed {
        logic ready;
        logic flag;
        logic ovr;
        logic unr;
    } nt_t;

    nt_t nt_d, nt_q;
    logic rise;

    always_comb begin
        nt_d = nt_q;
        rise = 1'b0;
        if (flush) begin
            nt_d = '0;
        end else begin
            nt_d.ready = (level_nx >= CW'(BURST));
            rise       = nt_d.ready && !nt_q.ready;
            nt_d.flag  = rise || (nt_q.flag && !clr_req);
            nt_d.ovr   = nt_q.ovr || ovf_evt;
            nt_d.unr   = nt_q.unr || unf_evt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) nt_q <= '0;
        else        nt_q <= nt_d;
    end

    assign ready    = nt_q.ready;
    assign flag     = nt_q.flag;
    assign irq      = nt_q.flag && !mask;
    assign overrun  = nt_q.ovr;
    assign underrun = nt_q.unr;

    a_r3_ready_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (level_q >= CW'(BURST)));
    a_r4_flag_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ready);
    a_r5_clear_when_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && ready && !flush) |=> !flag);
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !flush) |=> overrun);
endmodule

// File: rtl/rxburst_fifo.sv
module rxburst_fifo
    import rxb_pkg::*;
#(
    parameter int unsigned DEPTH = DEF_DEPTH,
    parameter int unsigned BURST = DEF_BURST,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       data_en,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    input  logic       rd_strobe,
    output logic [7:0] rd_byte,
    input  logic       irq_mask,
    input  logic       flag_clr,
    output logic       burst_ready,
    output logic       burst_flag,
    output logic       irq,
    output logic       overrun,
    output logic       underrun
);
    logic          flush;
    logic [CW-1:0] lvl_q, lvl_nx;
    logic          ovf_evt, unf_evt;

    assign flush = !data_en;

    rxb_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .wr_req   (in_valid),
        .wr_byte  (in_byte),
        .rd_req   (rd_strobe),
        .rd_byte  (rd_byte),
        .level_q  (lvl_q),
        .level_nx (lvl_nx),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt)
    );

    rxb_notify #(.DEPTH(DEPTH), .BURST(BURST)) u_notify (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .level_q  (lvl_q),
        .level_nx (lvl_nx),
        .clr_req  (flag_clr),
        .mask     (irq_mask),
        .ovf_evt  (ovf_evt),
        .unf_evt  (unf_evt),
        .ready    (burst_ready),
        .flag     (burst_flag),
        .irq      (irq),
        .overrun  (overrun),
        .underrun (underrun)
    );

    a_r6_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_mask |-> !irq);
    a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |=> (!burst_ready && !burst_flag && !overrun && !underrun));
endmodule

// File: tb/rxburst_fifo_tb.sv
module rxburst_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_en = 1'b0, in_valid = 1'b0, rd_strobe = 1'b0;
    logic       irq_mask = 1'b0, flag_clr = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic [7:0] rd_byte;
    logic       burst_ready, burst_flag, irq, overrun, underrun;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    byte unsigned q[$];
    logic [7:0] m_last = 8'h00;
    bit m_flag = 0, m_ovr = 0, m_unr = 0;

    always #5 clk = ~clk;

    rxburst_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .data_en(data_en), .in_valid(in_valid),
        .in_byte(in_byte), .rd_strobe(rd_strobe), .rd_byte(rd_byte),
        .irq_mask(irq_mask), .flag_clr(flag_clr), .burst_ready(burst_ready),
        .burst_flag(burst_flag), .irq(irq), .overrun(overrun), .underrun(underrun)
    );

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit exp_ready();
        return q.size() >= 8;
    endfunction

    task automatic check_all();
        chk("R2 rd_byte", rd_byte, m_last);
        chk("R3 burst_ready", burst_ready, exp_ready());
        chk("R4/R5 burst_flag", burst_flag, m_flag);
        chk("R6 irq", irq, m_flag && !irq_mask);
        chk("R8 overrun", overrun, m_ovr);
        chk("R7 underrun", underrun, m_unr);
    endtask

    // Model update for one edge, from the pre-edge state and inputs.
    task automatic model_edge(bit en, bit v, byte unsigned b, bit rd, bit clr);
        int old;
        bit full, emp, rise;
        if (!en) begin
            q.delete(); m_flag = 0; m_ovr = 0; m_unr = 0;
            return;
        end
        old  = q.size();
        full = (old == 16);
        emp  = (old == 0);
        if (rd) begin
            if (!emp) m_last = q.pop_front();
            else      m_unr = 1;
        end
        if (v) begin
            if (!full) q.push_back(b);
            else       m_ovr = 1;
        end
        rise   = (q.size() >= 8) && (old < 8);
        m_flag = rise || (m_flag && !clr);
    endtask

    // Called at a falling edge: drive, clock, compare at next falling edge.
    task automatic cyc(bit en, bit v, byte unsigned b, bit rd, bit clr, bit msk);
        data_en = en; in_valid = v; in_byte = b; rd_strobe = rd;
        flag_clr = clr; irq_mask = msk;
        @(posedge clk);
        model_edge(en, v, b, rd, clr);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check_all();
        chk("R1 reset ready", burst_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: disabled ignores stream
        for (int i = 0; i < 4; i++) cyc(0, 1, 8'hA0 + 8'(i), 0, 0, 0);
        chk("R1 disabled no ready", burst_ready, 0);

        // R2/R3/R4: fill 7 then 8th raises ready and flag
        for (int i = 0; i < 7; i++) cyc(1, 1, 8'h10 + 8'(i), 0, 0, 1);
        chk("R3 seven not ready", burst_ready, 0);
        cyc(1, 1, 8'h17, 0, 0, 1);
        chk("R4 flag on eighth", burst_flag, 1);
        chk("R6 masked irq low", irq, 0);
        cyc(1, 0, 0, 0, 0, 0);
        chk("R6 unmasked irq", irq, 1);

        // R8: fill to 16, then overflow
        for (int i = 0; i < 8; i++) cyc(1, 1, 8'h18 + 8'(i), 0, 0, 1);
        chk("R8 no overrun at 16", overrun, 0);
        cyc(1, 1, 8'hEE, 0, 0, 1);
        chk("R8 overrun set", overrun, 1);

        // R9: read+write while full: write dropped, read pops
        cyc(1, 1, 8'hDD, 1, 0, 1);
        chk("R2 first byte", rd_byte, 8'h10);
        // R9: balanced read/write mid-level
        cyc(1, 1, 8'h55, 1, 0, 1);
        chk("R9 level kept", q.size(), 15);

        // R5: clear flag while ready stays high
        cyc(1, 0, 0, 0, 1, 0);
        chk("R5 flag cleared", burst_flag, 0);

        // drain past empty: R7
        while (q.size() > 0) cyc(1, 0, 0, 1, 0, 0);
        cyc(1, 0, 0, 1, 0, 0);
        chk("R7 underrun set", underrun, 1);
        chk("R7 last byte held", rd_byte, 8'h55);

        // R5: clear on same edge as new rise -> stays set
        for (int i = 0; i < 7; i++) cyc(1, 1, 8'h30 + 8'(i), 0, 0, 1);
        cyc(1, 0, 0, 0, 1, 1);
        cyc(1, 1, 8'h37, 0, 1, 1);
        chk("R5 set wins over clear", burst_flag, 1);

        // R1: flush mid-block
        cyc(0, 0, 0, 1, 0, 0);
        chk("R1 flush ready", burst_ready, 0);
        chk("R1 flush errors", overrun | underrun, 0);

        // random traffic, fixed seed
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4000; i++) begin
            bit en  = ($urandom % 64) != 0;
            bit v   = ($urandom % 100) < 55;
            bit rd  = ($urandom % 100) < 45;
            bit clr = ($urandom % 10) == 0;
            bit msk = ($urandom % 4) == 0;
            cyc(en, v, 8'($urandom), rd, clr, msk);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule